// File: doc/BRIEF.md
# CAN Error Status and Confinement Unit

This block collects the error reporting of a CAN protocol controller into a single status word. The bit-stream engine gives it single-cycle pulses for four error kinds: a missing acknowledge, a CRC mismatch, a form violation and a stuffing violation. Each pulse latches a sticky flag. A read of the status word clears these flags. Any event that arrives in the same cycle as that read is kept.

The block takes the transmit and receive error counters as plain values. From them it derives two warning flags and the two-bit fault confinement state. It also detects entry into bus off and latches a bus-off flag, which software clears by writing 1 to that bit. An interrupt request leaves the block while that flag is set and its mask is enabled.

Listen-only mode forces the reported confinement state to error passive. A synchronous soft reset clears the latched flags but does not change that forced value. The bus idle and transmit/receive direction inputs are copied into the word so that software can see them.

Top module: `can_err_status`

## Requirements
- R1: After the asynchronous reset, the four error flags (bits 13..10) and the bus-off flag (bit 2) read 0, and `boff_irq_o` is 0.
- R2: A pulse on `evt_ack_i`, `evt_crc_i`, `evt_form_i` or `evt_stuff_i` sets bit 13, 12, 11 or 10 respectively from the next clock edge onward. The bit stays 1 until it is cleared.
- R3: A cycle with `rd_en_i`=1 clears bits 13..10 at the next edge. If an event pulse arrives in that same cycle, its bit stays 1.
- R4: Bit 9 is 1 exactly when `tx_cnt_i` >= 96. Bit 8 is 1 exactly when `rx_cnt_i` >= 96.
- R5: With `listen_only_i`=0, bits [5:4] read 2'b10 (bus off) when `tx_cnt_i` >= 256. They read 2'b01 (error passive) when either counter is >= 128. They read 2'b00 (error active) otherwise.
- R6: With `listen_only_i`=1, bits [5:4] read 2'b01 whatever the counter values.
- R7: Bit 2 becomes 1 at the edge that ends the first cycle in which the unforced state is bus off (`tx_cnt_i` >= 256 with `listen_only_i`=0) after a cycle in which it was not. It then holds.
- R8: A cycle with `wr_en_i`=1 and `wr_data_i[2]`=1 clears bit 2 at the next edge. With `wr_data_i[2]`=0 the write has no effect. A bus-off entry in the same cycle as a clearing write wins.
- R9: `boff_irq_o` equals bit 2 AND `boff_mask_i`.
- R10: Bit 7 follows `bus_idle_i` and bit 6 follows `bus_tx_i` in the same cycle.
- R11: A cycle with `soft_rst_i`=1 clears bits 13..10 and bit 2 at the next edge, whatever events arrive in that cycle. Bits [5:4] still read 2'b01 while `listen_only_i` stays 1.
- R12: Bits 15, 14, 3, 1 and 0 of `rd_data_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of latched flags |
| evt_ack_i | input | 1 | Acknowledge error pulse |
| evt_crc_i | input | 1 | CRC error pulse |
| evt_form_i | input | 1 | Form error pulse |
| evt_stuff_i | input | 1 | Stuffing error pulse |
| tx_cnt_i | input | 9 | Transmit error counter value |
| rx_cnt_i | input | 9 | Receive error counter value |
| listen_only_i | input | 1 | Listen-only mode enable |
| bus_idle_i | input | 1 | Bus is idle |
| bus_tx_i | input | 1 | 1 transmitting, 0 receiving |
| boff_mask_i | input | 1 | Bus-off interrupt enable |
| rd_en_i | input | 1 | Status word is read this cycle |
| wr_en_i | input | 1 | Status word is written this cycle |
| wr_data_i | input | 16 | Write data (bit 2 clears the bus-off flag) |
| rd_data_o | output | 16 | Status word |
| boff_irq_o | output | 1 | Bus-off interrupt request |

## Verification
Two pairs of actions can land in the same cycle. An event pulse can coincide with the read that clears the sticky flags, and a bus-off entry can coincide with a write of 1 to the bus-off bit. Directed cycles place each pair on the same edge, and the random phase produces many more such overlaps by chance. A bench model applies the rule that the setting action wins, and the word read after that edge must show the flag still at 1.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
   localparam int unsigned BIT_ACK   = 13;
   localparam int unsigned BIT_STUFF = 10;
   localparam int unsigned BIT_TXW   = 9;
   localparam int unsigned BIT_RXW   = 8;
   localparam int unsigned BIT_IDLE  = 7;
   localparam int unsigned BIT_DIR   = 6;
   localparam int unsigned BIT_FC_LO = 4;
   localparam int unsigned BIT_BOFF  = 2;
   localparam int unsigned N_EVT     = 4;
   localparam int unsigned MIN_DATA_W = BIT_ACK + 1;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_e;
endpackage

// File: rtl/can_err_sticky.sv
module can_err_sticky #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         rd_clr,
   input  logic [N-1:0] evt,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags[i] <= 1'b0;
         else if (soft_clr) flags[i] <= 1'b0;
         else if (evt[i])   flags[i] <= 1'b1;
         else if (rd_clr)   flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
   import can_err_pkg::*;
#(
   parameter int unsigned CNT_W    = 9,
   parameter int unsigned WARN_LVL = 96,
   parameter int unsigned PASS_LVL = 128,
   parameter int unsigned BOFF_LVL = 256
) (
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic [CNT_W-1:0] rx_cnt,
   input  logic             listen_only,
   output logic             tx_warn,
   output logic             rx_warn,
   output fc_e              fc,
   output logic             boff_state
);
   localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LVL);
   localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LVL);
   localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LVL);

   logic tx_pass, rx_pass, tx_off;

   assign tx_warn = (tx_cnt >= WARN_V);
   assign rx_warn = (rx_cnt >= WARN_V);
   assign tx_pass = (tx_cnt >= PASS_V);
   assign rx_pass = (rx_cnt >= PASS_V);
   assign tx_off  = (tx_cnt >= BOFF_V);

   assign boff_state = tx_off && !listen_only;

   always_comb begin
      if (listen_only)            fc = FC_PASSIVE;
      else if (tx_off)            fc = FC_BUSOFF;
      else if (tx_pass || rx_pass) fc = FC_PASSIVE;
      else                        fc = FC_ACTIVE;
   end
endmodule

// File: rtl/can_err_boff.sv
module can_err_boff (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_clr,
   input  logic boff_state,
   input  logic wr_clr,
   output logic flag
);
   logic state_q;
   logic entry;

   assign entry = boff_state && !state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         flag    <= 1'b0;
      end else begin
         state_q <= boff_state;
         if (soft_clr)    flag <= 1'b0;
         else if (entry)  flag <= 1'b1;
         else if (wr_clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/can_err_status.sv
module can_err_status
   import can_err_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CNT_W    = 9,
   parameter int unsigned WARN_LVL = 96,
   parameter int unsigned PASS_LVL = 128,
   parameter int unsigned BOFF_LVL = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              evt_ack_i,
   input  logic              evt_crc_i,
   input  logic              evt_form_i,
   input  logic              evt_stuff_i,
   input  logic [CNT_W-1:0]  tx_cnt_i,
   input  logic [CNT_W-1:0]  rx_cnt_i,
   input  logic              listen_only_i,
   input  logic              bus_idle_i,
   input  logic              bus_tx_i,
   input  logic              boff_mask_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              boff_irq_o
);
   if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
      $error("can_err_status: DATA_W too small for the status layout");
   end
   if (BOFF_LVL >= (1 << CNT_W) || !(WARN_LVL < PASS_LVL && PASS_LVL < BOFF_LVL)) begin : g_bad_lvl
      $error("can_err_status: thresholds must rise and fit CNT_W");
   end

   logic [N_EVT-1:0] evt_vec;
   logic [N_EVT-1:0] err_flags;
   logic             tx_warn, rx_warn, boff_state, boff_flag;
   fc_e              fc;

   assign evt_vec = {evt_ack_i, evt_crc_i, evt_form_i, evt_stuff_i};

   can_err_sticky #(.N(N_EVT)) u_sticky (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_rst_i),
      .rd_clr   (rd_en_i),
      .evt      (evt_vec),
      .flags    (err_flags)
   );

   can_err_confine #(
      .CNT_W    (CNT_W),
      .WARN_LVL (WARN_LVL),
      .PASS_LVL (PASS_LVL),
      .BOFF_LVL (BOFF_LVL)
   ) u_confine (
      .tx_cnt      (tx_cnt_i),
      .rx_cnt      (rx_cnt_i),
      .listen_only (listen_only_i),
      .tx_warn     (tx_warn),
      .rx_warn     (rx_warn),
      .fc          (fc),
      .boff_state  (boff_state)
   );

   can_err_boff u_boff (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr   (soft_rst_i),
      .boff_state (boff_state),
      .wr_clr     (wr_en_i && wr_data_i[BIT_BOFF]),
      .flag       (boff_flag)
   );

   always_comb begin
      rd_data_o = '0;
      rd_data_o[BIT_ACK:BIT_STUFF]       = err_flags;
      rd_data_o[BIT_TXW]                 = tx_warn;
      rd_data_o[BIT_RXW]                 = rx_warn;
      rd_data_o[BIT_IDLE]                = bus_idle_i;
      rd_data_o[BIT_DIR]                 = bus_tx_i;
      rd_data_o[BIT_FC_LO+1:BIT_FC_LO]   = fc;
      rd_data_o[BIT_BOFF]                = boff_flag;
   end

   assign boff_irq_o = boff_flag && boff_mask_i;
endmodule

// File: rtl/can_err_status_chk.sv
module can_err_status_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst_i,
   input logic              evt_ack_i,
   input logic              evt_stuff_i,
   input logic [CNT_W-1:0]  tx_cnt_i,
   input logic              listen_only_i,
   input logic              bus_idle_i,
   input logic              boff_mask_i,
   input logic              rd_en_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              boff_irq_o
);
   a_r2_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ack_i && !soft_rst_i) |=> rd_data_o[13]);
   a_r2_stuff_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_stuff_i && !soft_rst_i) |=> rd_data_o[10]);
   a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !evt_ack_i) |=> !rd_data_o[13]);
   a_r6_listen_passive: assert property (@(posedge clk) disable iff (!rst_n)
      listen_only_i |-> (rd_data_o[5:4] == 2'b01));
   a_r8_write0_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[2] && !soft_rst_i && !(wr_en_i && wr_data_i[2])) |=> rd_data_o[2]);
   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      boff_irq_o |-> (rd_data_o[2] && boff_mask_i));
   a_r10_idle_copy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[7] == bus_idle_i);
   a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> (rd_data_o[13:10] == 4'b0 && !rd_data_o[2]));
   a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[15:14] == 2'b0 && rd_data_o[3] == 1'b0 && rd_data_o[1:0] == 2'b0));
   a_r5_busoff_code: assert property (@(posedge clk) disable iff (!rst_n)
      (!listen_only_i && tx_cnt_i[CNT_W-1]) |-> (rd_data_o[5:4] == 2'b10));
endmodule

bind can_err_status can_err_status_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .soft_rst_i    (soft_rst_i),
   .evt_ack_i     (evt_ack_i),
   .evt_stuff_i   (evt_stuff_i),
   .tx_cnt_i      (tx_cnt_i),
   .listen_only_i (listen_only_i),
   .bus_idle_i    (bus_idle_i),
   .boff_mask_i   (boff_mask_i),
   .rd_en_i       (rd_en_i),
   .wr_en_i       (wr_en_i),
   .wr_data_i     (wr_data_i),
   .rd_data_o     (rd_data_o),
   .boff_irq_o    (boff_irq_o)
);

// File: tb/can_err_status_bench.sv
module can_err_status_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst_i = 1'b0;
   logic        evt_ack_i = 1'b0, evt_crc_i = 1'b0, evt_form_i = 1'b0, evt_stuff_i = 1'b0;
   logic [8:0]  tx_cnt_i = '0, rx_cnt_i = '0;
   logic        listen_only_i = 1'b0, bus_idle_i = 1'b0, bus_tx_i = 1'b0, boff_mask_i = 1'b0;
   logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] rd_data_o;
   logic        boff_irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [3:0] m_flags = '0;
   logic       m_boff = 1'b0;
   logic       m_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_err_status u_can_err_status (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
      .evt_ack_i(evt_ack_i), .evt_crc_i(evt_crc_i), .evt_form_i(evt_form_i), .evt_stuff_i(evt_stuff_i),
      .tx_cnt_i(tx_cnt_i), .rx_cnt_i(rx_cnt_i), .listen_only_i(listen_only_i),
      .bus_idle_i(bus_idle_i), .bus_tx_i(bus_tx_i), .boff_mask_i(boff_mask_i),
      .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .boff_irq_o(boff_irq_o)
   );

   function automatic logic [1:0] exp_fc();
      if (listen_only_i) return 2'b01;
      if (tx_cnt_i >= 9'd256) return 2'b10;
      if (tx_cnt_i >= 9'd128 || rx_cnt_i >= 9'd128) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [8:0] pick_cnt();
      case ($urandom_range(0, 9))
         0: return 9'd95;
         1: return 9'd96;
         2: return 9'd127;
         3: return 9'd128;
         4: return 9'd255;
         5: return 9'd256;
         default: return 9'($urandom_range(0, 511));
      endcase
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Check all outputs against the model, then advance one clock.
   task automatic step();
      #1;
      check("R2/R3 error flags", {12'b0, rd_data_o[13:10]}, {12'b0, m_flags});
      check("R4 warnings", {14'b0, rd_data_o[9:8]}, {14'b0, tx_cnt_i >= 9'd96, rx_cnt_i >= 9'd96});
      check("R10 idle/direction", {14'b0, rd_data_o[7:6]}, {14'b0, bus_idle_i, bus_tx_i});
      check(listen_only_i ? "R6 listen-only state" : "R5 confinement", {14'b0, rd_data_o[5:4]}, {14'b0, exp_fc()});
      check("R7/R8 bus-off flag", {15'b0, rd_data_o[2]}, {15'b0, m_boff});
      check("R9 irq", {15'b0, boff_irq_o}, {15'b0, m_boff & boff_mask_i});
      check("R12 unused bits", {rd_data_o[15:14], 10'b0, rd_data_o[3], 1'b0, rd_data_o[1:0]}, 16'b0);
      begin
         logic [3:0] ev = {evt_ack_i, evt_crc_i, evt_form_i, evt_stuff_i};
         logic now_off = (tx_cnt_i >= 9'd256) && !listen_only_i;
         logic entry = now_off && !m_prev;
         @(posedge clk);
         if (soft_rst_i) begin
            m_flags = '0; m_boff = 1'b0;
         end else begin
            m_flags = (rd_en_i ? 4'b0 : m_flags) | ev;
            if (entry) m_boff = 1'b1;
            else if (wr_en_i && wr_data_i[2]) m_boff = 1'b0;
         end
         m_prev = now_off;
      end
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      soft_rst_i = 0; evt_ack_i = 0; evt_crc_i = 0; evt_form_i = 0; evt_stuff_i = 0;
      rd_en_i = 0; wr_en_i = 0; wr_data_i = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      tx_cnt_i = 9'd10; rx_cnt_i = 9'd20; bus_idle_i = 1;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      // R1 reset state
      check("R1 reset flags", {rd_data_o[13:10], 11'b0, rd_data_o[2]}, 16'b0);
      check("R1 reset irq", {15'b0, boff_irq_o}, 16'b0);
      rst_n = 1;
      @(negedge clk);

      // R3: event and read in the same cycle keeps the flag
      evt_crc_i = 1; step(); idle_inputs();
      rd_en_i = 1; evt_ack_i = 1; step(); idle_inputs();
      #1 check("R3 event during read kept", {15'b0, rd_data_o[13]}, 16'd1);
      check("R3 read cleared crc", {15'b0, rd_data_o[12]}, 16'd0);
      rd_en_i = 1; step(); idle_inputs();

      // R7/R8: entry coincident with clearing write; then write 0; then write 1
      tx_cnt_i = 9'd255; step();
      tx_cnt_i = 9'd256; wr_en_i = 1; wr_data_i = 16'h0004; boff_mask_i = 1; step(); idle_inputs();
      #1 check("R8 entry beats clear", {15'b0, rd_data_o[2]}, 16'd1);
      wr_en_i = 1; wr_data_i = 16'hFFFB; step(); idle_inputs();
      #1 check("R8 write 0 no effect", {15'b0, rd_data_o[2]}, 16'd1);
      wr_en_i = 1; wr_data_i = 16'h0004; step(); idle_inputs();
      #1 check("R8 write 1 clears", {15'b0, rd_data_o[2]}, 16'd0);

      // R11: soft reset under listen-only
      listen_only_i = 1; evt_form_i = 1; step(); idle_inputs();
      soft_rst_i = 1; evt_stuff_i = 1; step(); idle_inputs();
      #1 check("R11 soft reset clears", {12'b0, rd_data_o[13:10]}, 16'd0);
      check("R11 listen-only kept passive", {14'b0, rd_data_o[5:4]}, 16'd1);
      listen_only_i = 0; step();

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         idle_inputs();
         evt_ack_i     = ($urandom_range(0, 9) == 0);
         evt_crc_i     = ($urandom_range(0, 9) == 0);
         evt_form_i    = ($urandom_range(0, 9) == 0);
         evt_stuff_i   = ($urandom_range(0, 9) == 0);
         rd_en_i       = ($urandom_range(0, 4) == 0);
         wr_en_i       = ($urandom_range(0, 4) == 0);
         wr_data_i     = 16'($urandom);
         soft_rst_i    = ($urandom_range(0, 40) == 0);
         listen_only_i = ($urandom_range(0, 5) == 0);
         bus_idle_i    = 1'($urandom);
         bus_tx_i      = 1'($urandom);
         boff_mask_i   = 1'($urandom);
         if ($urandom_range(0, 2) == 0) tx_cnt_i = pick_cnt();
         if ($urandom_range(0, 2) == 0) rx_cnt_i = pick_cnt();
         step();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule